// File: doc/BRIEF.md
# Cross-Domain RTC Control Register with Prescaler

This block holds the control settings of a real-time counter. Software writes an 8-bit value from the fast system clock domain. The value lands in a shadow register, and a busy flag rises at once. A toggle request then carries the settings into the slow RTC clock domain. There the settings are applied on the second RTC rising edge after the write. An acknowledge toggle returns through a synchronizer and clears the busy flag.

On the RTC side, the applied settings drive a power-of-two prescaler. A 4-bit code N selects division by 2^N, from 1 up to 32768. The prescaler produces a one-cycle tick enable for a downstream counter. Ticks are held off when the run bit is clear. They are also held off during standby unless the keep-running-in-standby bit is set. The frequency-correction bit is passed through unchanged to a downstream correction unit.

Top module: `rtc_ctrl_xdom`

## Requirements
- R1: After reset, the readback is 0x00, the busy flag is 0, the tick output is 0 and the correction output is 0.
- R2: A written value takes effect in the RTC domain on the second RTC rising edge after the system edge that accepted it. It has not taken effect after the first RTC edge.
- R3: The busy flag is 1 in the system cycle that follows an accepted write. It is still 1 when the RTC side applies the value. It returns to 0 once the acknowledge has come back.
- R4: A write presented while busy is 1 is ignored. The readback and the value applied in the RTC domain both stay those of the write already in flight.
- R5: The readback field layout is: bit 0 run enable, bit 1 unused and always read as 0, bit 2 correction enable, bits 6:3 prescaler code N, and bit 7 keep-running-in-standby.
- R6: While the applied run enable is 0, the tick output stays 0.
- R7: While the standby input is 1 and keep-running-in-standby is 0, the tick output stays 0. With keep-running-in-standby set to 1, ticks continue during standby.
- R8: With code N and ticking allowed, the tick is a one-cycle pulse every 2^N RTC cycles. N = 0 gives a tick every cycle, and N = 15 gives one tick per 32768 cycles.
- R9: When the applied code changes, or when the block was stopped before the new value is applied, the first tick falls in the 2^N-th RTC cycle. The count starts at 1 with the cycle in which the new value is applied.
- R10: The correction output equals bit 2 of the value applied in the RTC domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| sys_rst | input | 1 | Synchronous active-high reset, system domain |
| cfg_we | input | 1 | Write strobe for the control register |
| cfg_wdata | input | 8 | Value to write |
| cfg_rdata | output | 8 | Readback of the shadow register |
| cfg_busy | output | 1 | An accepted write is still crossing to the RTC domain |
| rtc_clk | input | 1 | RTC clock |
| rtc_rst | input | 1 | Synchronous active-high reset, RTC domain |
| standby_in | input | 1 | Standby indication, RTC domain |
| tick_en | output | 1 | One-cycle prescaled tick enable |
| corr_en | output | 1 | Frequency-correction enable for the downstream unit |

## Verification
Two events can fall in the same cycle: a second write arriving while the first is still in flight, and the RTC side applying that first value. The bench holds the write strobe high on the system edge that follows an accepted write, with a different value. The bench also changes the correction bit, so that the applied value is visible at the ports. It judges the result from the correction output at the apply edge, the busy flag at that moment, the tick phase after the apply edge, and the readback once busy has cleared. All of these must match the first value, and the tick phase must restart from the apply cycle.

// File: rtl/rtcx_pkg.sv
package rtcx_pkg;

    localparam int unsigned PRE_W  = 15;
    localparam int unsigned CODE_W = 4;

    // Bit positions are those software sees in the readback.
    typedef struct packed {
        logic              stby_run;
        logic [CODE_W-1:0] div_sel;
        logic              corr_on;
        logic              rsvd;
        logic              run_on;
    } rtc_cfg_t;

    // Convert a bus word to settings; the unused bit is forced to zero.
    function automatic rtc_cfg_t cfg_from_bus(input logic [7:0] d);
        rtc_cfg_t c;
        c      = rtc_cfg_t'(d);
        c.rsvd = 1'b0;
        return c;
    endfunction

endpackage

// File: rtl/rtcx_sync.sv
module rtcx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rtcx_sys_if.sv
module rtcx_sys_if
    import rtcx_pkg::*;
#(
    parameter int unsigned ACK_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     we,
    input  logic [7:0] wdata,
    input  logic     ack_tgl,
    output rtc_cfg_t shadow,
    output logic     req_tgl,
    output logic     busy
);
    logic ack_seen;

    rtcx_sync #(.STAGES(ACK_STAGES)) u_ack_sync (
        .clk (clk),
        .rst (rst),
        .d   (ack_tgl),
        .q   (ack_seen)
    );

    // Busy lasts from the accepting edge until the acknowledge has returned.
    assign busy = req_tgl ^ ack_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow  <= '0;
            req_tgl <= 1'b0;
        end else if (we && !busy) begin
            shadow  <= cfg_from_bus(wdata);
            req_tgl <= ~req_tgl;
        end
    end

    p_busy_set_r3: assert property (@(posedge clk) disable iff (rst)
        (we && !busy) |=> busy);

    p_keep_inflight_r4: assert property (@(posedge clk) disable iff (rst)
        (we && busy) |=> ($stable(shadow) && $stable(req_tgl)));
endmodule

// File: rtl/rtcx_rtc_apply.sv
module rtcx_rtc_apply
    import rtcx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  rtc_cfg_t shadow,
    input  logic     req_tgl,
    output rtc_cfg_t active,
    output logic     ack_tgl,
    output logic     code_clr
);
    logic req_s1, req_s2;
    logic apply;

    // The settings load on the same edge on which the second flop takes the
    // request, which is two RTC edges after the write.
    assign apply    = req_s1 ^ req_s2;
    assign code_clr = apply && (shadow.div_sel != active.div_sel);
    assign ack_tgl  = req_s2;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_s1 <= 1'b0;
            req_s2 <= 1'b0;
            active <= '0;
        end else begin
            req_s1 <= req_tgl;
            req_s2 <= req_s1;
            if (apply) active <= shadow;
        end
    end

    p_ack_follows_r3: assert property (@(posedge clk) disable iff (rst)
        apply |=> (ack_tgl == $past(req_s1)));
endmodule

// File: rtl/rtcx_prescale.sv
module rtcx_prescale
    import rtcx_pkg::*;
#(
    parameter int unsigned CNT_W = PRE_W
) (
    input  logic     clk,
    input  logic     rst,
    input  rtc_cfg_t cfg,
    input  logic     standby,
    input  logic     clr,
    output logic     tick
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] wrap_mask;
    logic             gate;

    // Shifting by the full width wraps to zero, so the mask becomes all ones.
    assign wrap_mask = (CNT_W'(1) << cfg.div_sel) - CNT_W'(1);
    assign gate      = cfg.run_on && (!standby || cfg.stby_run);
    assign tick      = gate && ((cnt & wrap_mask) == wrap_mask);

    always_ff @(posedge clk) begin
        if (rst)                  cnt <= '0;
        else if (clr || !cfg.run_on) cnt <= '0;
        else if (gate)            cnt <= cnt + CNT_W'(1);
    end

    p_idle_when_off_r6: assert property (@(posedge clk) disable iff (rst)
        !cfg.run_on |-> !tick);

    p_standby_gate_r7: assert property (@(posedge clk) disable iff (rst)
        (standby && !cfg.stby_run) |-> !tick);

    p_restart_r9: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0));
endmodule

// File: rtl/rtc_ctrl_xdom.sv
module rtc_ctrl_xdom
    import rtcx_pkg::*;
#(
    parameter int unsigned CNT_W      = PRE_W,
    parameter int unsigned ACK_STAGES = 2
) (
    input  logic       sys_clk,
    input  logic       sys_rst,
    input  logic       cfg_we,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] cfg_rdata,
    output logic       cfg_busy,
    input  logic       rtc_clk,
    input  logic       rtc_rst,
    input  logic       standby_in,
    output logic       tick_en,
    output logic       corr_en
);
    localparam int unsigned MAX_CODE = (1 << CODE_W) - 1;

    rtc_cfg_t shadow;
    rtc_cfg_t active;
    logic     req_tgl;
    logic     ack_tgl;
    logic     code_clr;

    rtcx_sys_if #(.ACK_STAGES(ACK_STAGES)) u_sys (
        .clk     (sys_clk),
        .rst     (sys_rst),
        .we      (cfg_we),
        .wdata   (cfg_wdata),
        .ack_tgl (ack_tgl),
        .shadow  (shadow),
        .req_tgl (req_tgl),
        .busy    (cfg_busy)
    );

    rtcx_rtc_apply u_rtc (
        .clk      (rtc_clk),
        .rst      (rtc_rst),
        .shadow   (shadow),
        .req_tgl  (req_tgl),
        .active   (active),
        .ack_tgl  (ack_tgl),
        .code_clr (code_clr)
    );

    rtcx_prescale #(.CNT_W(CNT_W)) u_pre (
        .clk     (rtc_clk),
        .rst     (rtc_rst),
        .cfg     (active),
        .standby (standby_in),
        .clr     (code_clr),
        .tick    (tick_en)
    );

    assign cfg_rdata = shadow;
    assign corr_en   = active.corr_on;

    initial begin
        a_width_r8: assert (CNT_W == MAX_CODE);
    end
endmodule

// File: tb/rtc_ctrl_xdom_test.sv
module rtc_ctrl_xdom_test;
    timeunit 1ns;
    timeprecision 100ps;

    logic       sys_clk = 1'b0;
    logic       rtc_clk = 1'b0;
    logic       sys_rst = 1'b1;
    logic       rtc_rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       standby_in = 1'b0;
    logic [7:0] cfg_rdata;
    logic       cfg_busy, tick_en, corr_en;

    int checks = 0;
    int errors = 0;
    logic [7:0] cur = 8'h00;

    always #4 sys_clk = ~sys_clk;   // 125 MHz
    always #7 rtc_clk = ~rtc_clk;

    rtc_ctrl_xdom uut (
        .sys_clk(sys_clk), .sys_rst(sys_rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .cfg_busy(cfg_busy), .rtc_clk(rtc_clk), .rtc_rst(rtc_rst),
        .standby_in(standby_in), .tick_en(tick_en), .corr_en(corr_en)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] canon(input logic [7:0] v);
        return v & 8'hFD;
    endfunction

    function automatic bit gate_exp(input logic [7:0] v, input bit stby);
        return v[0] && (!stby || v[7]);
    endfunction

    function automatic int period_of(input logic [7:0] v);
        return 1 << v[6:3];
    endfunction

    task automatic set_standby(input bit s);
        @(negedge rtc_clk);
        standby_in = s;
    endtask

    // Write v (optionally followed by a rejected write of v2), then check
    // the apply latency, the tick phase over win cycles and the readback.
    task automatic wr(input logic [7:0] v, input int win, input bit dbl, input logic [7:0] v2);
        int mism;
        int p;
        int t;
        bit g;
        bit e;
        @(negedge sys_clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(posedge sys_clk);
        #0.5;
        chk(cfg_busy == 1'b1, "R3", "busy after write", int'(cfg_busy), 1);
        fork
            begin
                if (dbl) begin
                    cfg_wdata = v2;
                    @(posedge sys_clk);
                    #0.5;
                end
                cfg_we = 1'b0;
            end
        join_none
        @(posedge rtc_clk);
        #1;
        chk(corr_en == cur[2], "R2", "value not yet applied after one RTC edge", int'(corr_en), int'(cur[2]));
        @(posedge rtc_clk);
        #1;
        chk(corr_en == v[2], "R2 R10", "value applied after two RTC edges", int'(corr_en), int'(v[2]));
        chk(cfg_busy == 1'b1, "R3", "busy still set at apply", int'(cfg_busy), 1);
        p = period_of(v);
        g = gate_exp(v, standby_in);
        mism = 0;
        for (int i = 0; i < win; i++) begin
            e = g && ((i % p) == (p - 1));
            if (tick_en !== e) mism++;
            @(posedge rtc_clk);
            #1;
        end
        chk(mism == 0, g ? "R8 R9" : (v[0] ? "R7" : "R6"), "tick pattern mismatches", mism, 0);
        t = 0;
        while (cfg_busy && t < 200) begin
            @(posedge sys_clk);
            #0.5;
            t++;
        end
        chk(cfg_busy == 1'b0, "R3", "busy cleared after acknowledge", int'(cfg_busy), 0);
        chk(cfg_rdata == canon(v), dbl ? "R4" : "R5", "readback", int'(cfg_rdata), int'(canon(v)));
        cur = canon(v);
    endtask

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [3:0] code;
        logic [3:0] prev_code;
        bit stby;
        void'($urandom(32'd1234));
        repeat (6) @(posedge rtc_clk);
        @(negedge sys_clk);
        sys_rst = 1'b0;
        rtc_rst = 1'b0;
        @(negedge rtc_clk);
        #1;
        // R1
        chk(cfg_rdata == 8'h00, "R1", "reset readback", int'(cfg_rdata), 0);
        chk(cfg_busy == 1'b0, "R1", "reset busy", int'(cfg_busy), 0);
        chk(tick_en == 1'b0, "R1", "reset tick", int'(tick_en), 0);
        chk(corr_en == 1'b0, "R1", "reset correction", int'(corr_en), 0);

        // R8 with N = 0: every cycle
        wr(8'h05, 10, 1'b0, 8'h00);
        // N = 3, correction off
        wr(8'h19, 24, 1'b0, 8'h00);
        // R4: second write lands while busy, same cycle region as apply path
        wr(8'h2D, 96, 1'b1, 8'h01);
        // R7: standby without keep-running
        set_standby(1'b1);
        wr(8'h09, 20, 1'b0, 8'h00);
        // R7: standby with keep-running
        wr(8'h8D, 8, 1'b0, 8'h00);
        // R6: run off
        wr(8'h10, 20, 1'b0, 8'h00);
        set_standby(1'b0);
        // R5: unused bit reads as zero
        wr(8'h17, 12, 1'b0, 8'h00);

        prev_code = cur[6:3];
        for (int k = 0; k < 20; k++) begin
            do code = 4'($urandom_range(0, 5)); while (code == prev_code);
            prev_code = code;
            stby = 1'($urandom_range(0, 1));
            set_standby(stby);
            v = 8'($urandom_range(0, 255));
            v[6:3] = code;
            v[2] = ~cur[2];
            wr(v, gate_exp(v, stby) ? (2 * period_of(v) + 2) : 16, 1'b0, 8'h00);
        end
        set_standby(1'b0);

        // R8: largest code, one tick per 32768 cycles
        v = 8'h79;
        v[2] = ~cur[2];
        wr(v, 32769, 1'b0, 8'h00);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule